// File: doc/BRIEF.md
# Interleaved Random-Walk Chain Controller

This block steers a set of interleaved random-walk chains through an external point-addition pipeline. The pipeline has exactly as many register stages as there are chains. The controller serves one chain slot per clock in strict rotation. A step issued for a slot therefore returns its result at the slot's next turn.

For each step, the low five bits of the chain's current x-coordinate select one of 32 constant points. The chain's two scalar coefficients are advanced by that constant's coefficients, modulo the group order. The addition uses a two-stage split-carry adder.

Each returned point is screened before the chain continues:

- A point whose top x bits match a fixed nonzero pattern is a distinguished point. It is handed out with its coefficients through a valid/ready port, and its chain is retired.
- A chain that reaches the point at infinity is retired silently.
- A chain that exceeds its step budget is retired silently.

A retired slot waits for its next turn, takes a fresh starting point there if one is offered, and otherwise stays pending and issues nothing.

Top module: `walk_chain_ctrl`

## Requirements
- R1: Slots are served one per clock in rotation; `iss_slot` counts 0,1,…,NCH-1 and wraps to 0, and the result of a step issued for a slot is taken on `res_*` exactly NCH cycles later, when that slot is served again.
- R2: The partition index `iss_part` of every issued step equals bits [4:0] of `iss_x`.
- R3: Constant point k (0..31) carries coefficients e_k = (37·k + 11) mod ORDER and f_k = (53·k + 5) mod ORDER.
- R4: Each issued step replaces the chain's coefficients by c' = (c + e_k) mod ORDER and d' = (d + f_k) mod ORDER, where k is the step's partition; a reported point carries the coefficients after every step that led to it.
- R5: A returned point whose x bits [XW-1:XW-3] equal 3'b101 is distinguished: x, y, c, d and slot appear on `dp_*` with `dp_valid` high one cycle after that serve cycle, and the chain is retired without issuing a step.
- R6: A returned point flagged `res_inf` retires the chain with no step issued and no report, even if its x bits would match the pattern.
- R7: A chain issues at most MAX_LEN+1 steps: when a non-distinguished result would bring its completed step count above MAX_LEN, the chain is retired with no step and no report.
- R8: `start_ready` is high exactly in serve cycles of a retired (idle) slot; if `start_valid` is then high, the start point (x, y, c, d) is taken and a step for it is issued in that same cycle, otherwise the slot issues nothing.
- R9: A slot retired in one serve cycle neither takes a start point nor issues a step before its next turn.
- R10: While `dp_valid` is high and `dp_ready` low, every `dp_*` output holds its value; a distinguished point found while the port is busy is kept in its slot and reported at a later turn of that slot when the port is free.
- R11: After reset every slot is idle, `dp_valid` is low and `iss_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | A fresh starting point is offered |
| start_ready | output | 1 | Current slot is idle and accepts the starting point |
| start_x | input | XW | Start point x-coordinate |
| start_y | input | XW | Start point y-coordinate |
| start_c | input | CW | Start coefficient c (below ORDER) |
| start_d | input | CW | Start coefficient d (below ORDER) |
| iss_valid | output | 1 | A step enters the point-addition pipeline this cycle |
| iss_slot | output | SW | Slot served this cycle |
| iss_part | output | 5 | Constant point selected for the step |
| iss_x | output | XW | Current x of the stepping chain |
| iss_y | output | XW | Current y of the stepping chain |
| res_x | input | XW | Result x returned for the served slot |
| res_y | input | XW | Result y returned for the served slot |
| res_inf | input | 1 | Returned result is the point at infinity |
| dp_valid | output | 1 | Distinguished point report is valid |
| dp_ready | input | 1 | Consumer accepts the report |
| dp_slot | output | SW | Slot that produced the report |
| dp_x | output | XW | Distinguished point x |
| dp_y | output | XW | Distinguished point y |
| dp_c | output | CW | Coefficient c of the reported point |
| dp_d | output | CW | Coefficient d of the reported point |

## Verification
The issue outputs and `start_ready` are combinational from slot state and inputs, so they are due in the serve cycle itself. A step's result returns NCH cycles later through a bench pipeline stub, and a distinguished point appears on `dp_*` one cycle after the serve cycle that found it. The coefficient write-back lands two edges after issue and is only visible at the slot's next report. The bench drives inputs on the falling edge, compares all outputs 1 ns later against a per-slot model built from the requirements, and only then advances that model. This keeps every comparison in the cycle where each result is due. Stimulus phases withhold start points, throttle `dp_ready` and force infinity results, so that pending slots, held reports, length retirement and infinity retirement all occur.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int PART_W = 5;
    localparam int NPART  = 1 << PART_W;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WALK = 2'd1,
        SLOT_HOLD = 2'd2
    } slot_st_e;
endpackage

// File: rtl/walk_const_tbl.sv
module walk_const_tbl #(
    parameter int CW    = 12,
    parameter int ORDER = 4001,
    parameter int MUL   = 37,
    parameter int ADD   = 11
) (
    input  logic [walk_pkg::PART_W-1:0] idx,
    output logic [CW-1:0]               val
);
    logic [CW-1:0] tbl [walk_pkg::NPART];

    for (genvar k = 0; k < walk_pkg::NPART; k++) begin : g_ent
        localparam int V = (MUL * k + ADD) % ORDER;
        assign tbl[k] = V[CW-1:0];
    end

    assign val = tbl[idx];
endmodule

// File: rtl/walk_mod_add.sv
module walk_mod_add #(
    parameter int CW    = 12,
    parameter int ORDER = 4001,
    parameter int TW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [TW-1:0] in_tag,
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic          out_vld,
    output logic [TW-1:0] out_tag,
    output logic [CW-1:0] out_sum
);
    localparam int LO = CW / 2;
    localparam int HI = CW - LO;
    localparam logic [CW:0] ORD = (CW+1)'(ORDER);

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
        logic [LO:0]   lo;
        logic [HI-1:0] ah;
        logic [HI-1:0] bh;
    } stg_t;

    stg_t        s_d, s_q;
    logic [CW:0] full;

    always_comb begin
        s_d.vld = in_vld;
        s_d.tag = in_tag;
        s_d.lo  = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]};
        s_d.ah  = a[CW-1:LO];
        s_d.bh  = b[CW-1:LO];
        full    = {({1'b0, s_q.ah} + {1'b0, s_q.bh} + {{HI{1'b0}}, s_q.lo[LO]}),
                   s_q.lo[LO-1:0]};
        if (full >= ORD) out_sum = CW'(full - ORD);
        else             out_sum = full[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_vld = s_q.vld;
    assign out_tag = s_q.tag;

    // R4: operands below the order must give a residue below the order
    a_r4_sum_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_sum < CW'(ORDER)));
    a_r4_operands_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> (a < CW'(ORDER)) && (b < CW'(ORDER)));
endmodule

// File: rtl/walk_chain_ctrl.sv
module walk_chain_ctrl #(
    parameter int NCH     = 4,
    parameter int XW      = 16,
    parameter int CW      = 12,
    parameter int ORDER   = 4001,
    parameter int DP_BITS = 3,
    parameter int DP_PAT  = 5,
    parameter int MAX_LEN = 6,
    parameter int E_MUL   = 37,
    parameter int E_ADD   = 11,
    parameter int F_MUL   = 53,
    parameter int F_ADD   = 5,
    localparam int SW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    output logic          start_ready,
    input  logic [XW-1:0] start_x,
    input  logic [XW-1:0] start_y,
    input  logic [CW-1:0] start_c,
    input  logic [CW-1:0] start_d,
    output logic          iss_valid,
    output logic [SW-1:0] iss_slot,
    output logic [4:0]    iss_part,
    output logic [XW-1:0] iss_x,
    output logic [XW-1:0] iss_y,
    input  logic [XW-1:0] res_x,
    input  logic [XW-1:0] res_y,
    input  logic          res_inf,
    output logic          dp_valid,
    input  logic          dp_ready,
    output logic [SW-1:0] dp_slot,
    output logic [XW-1:0] dp_x,
    output logic [XW-1:0] dp_y,
    output logic [CW-1:0] dp_c,
    output logic [CW-1:0] dp_d
);
    import walk_pkg::*;

    localparam int LW = $clog2(MAX_LEN + 2);
    localparam logic [SW-1:0] LAST = SW'(NCH - 1);

    typedef struct packed {
        slot_st_e      st;
        logic [XW-1:0] x;
        logic [XW-1:0] y;
        logic [CW-1:0] c;
        logic [CW-1:0] d;
        logic [LW-1:0] len;
    } slot_t;

    typedef struct packed {
        slot_t [NCH-1:0] slots;
        logic [SW-1:0]   ptr;
        logic            dp_vld;
        logic [SW-1:0]   dp_slot;
        logic [XW-1:0]   dp_x;
        logic [XW-1:0]   dp_y;
        logic [CW-1:0]   dp_c;
        logic [CW-1:0]   dp_d;
    } state_t;

    state_t        st_d, st_q;
    slot_t         cur, nxt;
    logic          iss_vld_c, ld_c, rep_c, out_free, is_dp;
    logic [XW-1:0] ix, iy, rep_x, rep_y;
    logic [CW-1:0] c_src, d_src, e_k, f_k;
    logic          ca_vld, da_vld;
    logic [SW-1:0] ca_tag, da_tag;
    logic [CW-1:0] ca_sum, da_sum;

    walk_const_tbl #(.CW(CW), .ORDER(ORDER), .MUL(E_MUL), .ADD(E_ADD))
        i_etbl (.idx(ix[4:0]), .val(e_k));
    walk_const_tbl #(.CW(CW), .ORDER(ORDER), .MUL(F_MUL), .ADD(F_ADD))
        i_ftbl (.idx(ix[4:0]), .val(f_k));

    walk_mod_add #(.CW(CW), .ORDER(ORDER), .TW(SW)) i_cadd (
        .clk(clk), .rst_n(rst_n), .in_vld(iss_vld_c), .in_tag(st_q.ptr),
        .a(c_src), .b(e_k), .out_vld(ca_vld), .out_tag(ca_tag), .out_sum(ca_sum));
    walk_mod_add #(.CW(CW), .ORDER(ORDER), .TW(SW)) i_dadd (
        .clk(clk), .rst_n(rst_n), .in_vld(iss_vld_c), .in_tag(st_q.ptr),
        .a(d_src), .b(f_k), .out_vld(da_vld), .out_tag(da_tag), .out_sum(da_sum));

    always_comb begin
        st_d      = st_q;
        cur       = st_q.slots[st_q.ptr];
        nxt       = cur;
        iss_vld_c = 1'b0;
        ld_c      = 1'b0;
        rep_c     = 1'b0;
        ix        = res_x;
        iy        = res_y;
        rep_x     = res_x;
        rep_y     = res_y;
        c_src     = cur.c;
        d_src     = cur.d;
        out_free  = !st_q.dp_vld || dp_ready;
        is_dp     = (res_x[XW-1 -: DP_BITS] == DP_PAT[DP_BITS-1:0]);

        st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        if (st_q.dp_vld && dp_ready) st_d.dp_vld = 1'b0;

        unique case (cur.st)
            SLOT_IDLE: begin
                ld_c = 1'b1;
                if (start_valid) begin
                    iss_vld_c = 1'b1;
                    ix        = start_x;
                    iy        = start_y;
                    c_src     = start_c;
                    d_src     = start_d;
                    nxt.st    = SLOT_WALK;
                    nxt.len   = '0;
                end
            end
            SLOT_WALK: begin
                if (res_inf) begin
                    nxt.st = SLOT_IDLE;
                end else if (is_dp) begin
                    if (out_free) begin
                        rep_c  = 1'b1;
                        nxt.st = SLOT_IDLE;
                    end else begin
                        nxt.st = SLOT_HOLD;
                        nxt.x  = res_x;
                        nxt.y  = res_y;
                    end
                end else if (cur.len + LW'(1) > LW'(MAX_LEN)) begin
                    nxt.st = SLOT_IDLE;
                end else begin
                    iss_vld_c = 1'b1;
                    nxt.len   = cur.len + LW'(1);
                end
            end
            SLOT_HOLD: begin
                if (out_free) begin
                    rep_c  = 1'b1;
                    rep_x  = cur.x;
                    rep_y  = cur.y;
                    nxt.st = SLOT_IDLE;
                end
            end
            default: nxt.st = SLOT_IDLE;
        endcase

        if (rep_c) begin
            st_d.dp_vld  = 1'b1;
            st_d.dp_slot = st_q.ptr;
            st_d.dp_x    = rep_x;
            st_d.dp_y    = rep_y;
            st_d.dp_c    = cur.c;
            st_d.dp_d    = cur.d;
        end

        st_d.slots[st_q.ptr] = nxt;
        if (ca_vld) st_d.slots[ca_tag].c = ca_sum;
        if (da_vld) st_d.slots[da_tag].d = da_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_ready = ld_c;
    assign iss_valid   = iss_vld_c;
    assign iss_slot    = st_q.ptr;
    assign iss_part    = ix[4:0];
    assign iss_x       = ix;
    assign iss_y       = iy;
    assign dp_valid    = st_q.dp_vld;
    assign dp_slot     = st_q.dp_slot;
    assign dp_x        = st_q.dp_x;
    assign dp_y        = st_q.dp_y;
    assign dp_c        = st_q.dp_c;
    assign dp_d        = st_q.dp_d;

    // R4: write-back lands two edges after issue, so the rotation must be longer
    initial a_r4_depth_ok: assert (NCH >= 2);

    // R1: one slot per clock, wrapping after the last
    a_r1_slot_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> iss_slot == (($past(iss_slot) == LAST) ? '0 : $past(iss_slot) + 1'b1));

    // R5: every report matches the distinguished pattern
    a_r5_dp_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid |-> dp_x[XW-1 -: DP_BITS] == DP_PAT[DP_BITS-1:0]);

    // R6: an infinity result never continues the walk
    a_r6_inf_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.st == SLOT_WALK) && res_inf |-> !iss_valid);

    // R7: completed step count never exceeds the budget
    a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cur.len <= LW'(MAX_LEN));

    // R10: a stalled report holds still
    a_r10_dp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && !dp_ready |=> dp_valid && $stable(dp_x) && $stable(dp_y)
                                  && $stable(dp_c) && $stable(dp_d) && $stable(dp_slot));
endmodule

// File: tb/test_walk_chain_ctrl.sv
module test_walk_chain_ctrl;
    localparam int NCH     = 4;
    localparam int XW      = 16;
    localparam int CW      = 12;
    localparam int ORDER   = 4001;
    localparam int MAX_LEN = 6;
    localparam int SW      = 2;
    localparam int NCYC    = 1800;
    localparam int NSTART  = 16;

    // start vectors {x, y, c, d}; c and d stay below ORDER, some near it
    localparam logic [55:0] START_TBL [NSTART] = '{
        {16'h1234, 16'h0F0F, 12'h000, 12'h001},
        {16'hBEEF, 16'h4321, 12'hFA0, 12'hF9F},
        {16'h0013, 16'h7777, 12'h123, 12'h456},
        {16'hA5A5, 16'h5A5A, 12'hF00, 12'h0FF},
        {16'h3C1F, 16'h0001, 12'h7FF, 12'h800},
        {16'hFFFF, 16'hFFFF, 12'hF9E, 12'h002},
        {16'h0000, 16'h8000, 12'h555, 12'hAAA},
        {16'h6D2B, 16'h1F1F, 12'h010, 12'hF80},
        {16'h9001, 16'h2468, 12'h3E8, 12'h7D0},
        {16'h4C4C, 16'hC4C4, 12'hFA0, 12'hFA0},
        {16'h0F1E, 16'h2D3C, 12'h0AB, 12'hCDE},
        {16'hB00B, 16'h1357, 12'h999, 12'h111},
        {16'h2A2A, 16'h3B3B, 12'h222, 12'h333},
        {16'hE1E1, 16'h0ACE, 12'hEEE, 12'h0EE},
        {16'h7531, 16'h8642, 12'h600, 12'h060},
        {16'hC0DE, 16'hF00D, 12'h006, 12'hF99}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_valid, start_ready;
    logic [XW-1:0] start_x, start_y;
    logic [CW-1:0] start_c, start_d;
    logic          iss_valid;
    logic [SW-1:0] iss_slot;
    logic [4:0]    iss_part;
    logic [XW-1:0] iss_x, iss_y;
    logic [XW-1:0] res_x, res_y;
    logic          res_inf;
    logic          dp_valid, dp_ready;
    logic [SW-1:0] dp_slot;
    logic [XW-1:0] dp_x, dp_y;
    logic [CW-1:0] dp_c, dp_d;

    always #10 clk = ~clk;

    walk_chain_ctrl #(.NCH(NCH), .XW(XW), .CW(CW), .ORDER(ORDER), .MAX_LEN(MAX_LEN))
    i_walk_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .start_x(start_x), .start_y(start_y), .start_c(start_c), .start_d(start_d),
        .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_part(iss_part),
        .iss_x(iss_x), .iss_y(iss_y), .res_x(res_x), .res_y(res_y), .res_inf(res_inf),
        .dp_valid(dp_valid), .dp_ready(dp_ready), .dp_slot(dp_slot),
        .dp_x(dp_x), .dp_y(dp_y), .dp_c(dp_c), .dp_d(dp_d));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R3: constant coefficients
    function automatic logic [CW-1:0] e_of(input int k);
        return CW'((37 * k + 11) % ORDER);
    endfunction
    function automatic logic [CW-1:0] f_of(input int k);
        return CW'((53 * k + 5) % ORDER);
    endfunction

    // pipeline stub: an arbitrary mixing of the point and partition
    function automatic logic [XW-1:0] stub_x(input logic [XW-1:0] x, input logic [XW-1:0] y,
                                              input logic [4:0] p);
        return XW'(x * 16'd40503) ^ y ^ XW'({11'd0, p} * 16'h9E37) ^ 16'h1234;
    endfunction
    function automatic logic [XW-1:0] stub_y(input logic [XW-1:0] x, input logic [XW-1:0] y,
                                              input logic [4:0] p);
        return x ^ {y[XW-2:0], y[XW-1]} ^ {11'd0, p};
    endfunction

    // bench model, one entry per slot: 0 idle, 1 walking, 2 holding a report
    int            mst  [NCH];
    int            mlen [NCH];
    logic [CW-1:0] mc   [NCH];
    logic [CW-1:0] md   [NCH];
    logic [XW-1:0] mx   [NCH];
    logic [XW-1:0] my   [NCH];
    int            mptr;
    logic          mdv;
    logic [SW-1:0] mdslot;
    logic [XW-1:0] mdx, mdy;
    logic [CW-1:0] mdc, mdd;

    logic          pv   [NCH];
    logic          pinf [NCH];
    logic [XW-1:0] px   [NCH];
    logic [XW-1:0] py   [NCH];

    int cnt_dp = 0, cnt_hold = 0, cnt_len = 0, cnt_inf = 0, cnt_pend = 0;

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int tix = 0;
        rst_n = 1'b0; start_valid = 1'b0; start_x = '0; start_y = '0;
        start_c = '0; start_d = '0; res_x = '0; res_y = '0; res_inf = 1'b0;
        dp_ready = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            mst[i] = 0; mlen[i] = 0; mc[i] = '0; md[i] = '0; mx[i] = '0; my[i] = '0;
            pv[i] = 1'b0; pinf[i] = 1'b0; px[i] = '0; py[i] = '0;
        end
        mptr = 0; mdv = 1'b0; mdslot = '0; mdx = '0; mdy = '0; mdc = '0; mdd = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 dp_valid after reset", 32'(dp_valid), 32'd0);
        chk("R11 iss_slot after reset", 32'(iss_slot), 32'd0);
        chk("R11 slot idle after reset (start_ready)", 32'(start_ready), 32'd1);
        chk("R11 no issue without start", 32'(iss_valid), 32'd0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit            sv, dpr, free, e_iv, e_sr, rep, force_inf;
            logic [XW-1:0] ix, iy, rx, ry, qx, qy;
            logic [CW-1:0] cin, din;
            logic          qinf, qv;
            int            s;
            string         why;

            // stimulus phases
            sv  = 1'b1;
            dpr = 1'b1;
            force_inf = 1'b0;
            if (cyc >= 600 && cyc < 1200) begin
                sv  = (cyc % 5) != 0;
                dpr = (cyc % 9) < 3;
            end
            if (cyc >= 1200 && cyc < 1500) force_inf = 1'b1;
            if (cyc >= 1500 && cyc < 1560) sv = 1'b0;

            start_valid = sv;
            {start_x, start_y, start_c, start_d} = START_TBL[tix];
            dp_ready = dpr;
            res_x    = px[NCH-1];
            res_y    = py[NCH-1];
            res_inf  = pv[NCH-1] && pinf[NCH-1];
            #1;

            // expected values for this serve cycle
            s    = mptr;
            free = !mdv || dpr;
            e_iv = 1'b0; e_sr = 1'b0; rep = 1'b0;
            ix = res_x; iy = res_y; rx = res_x; ry = res_y;
            cin = mc[s]; din = md[s];
            why = "R1";
            if (mst[s] == 0) begin
                e_sr = 1'b1;
                why  = "R8";
                if (sv) begin
                    e_iv = 1'b1; ix = start_x; iy = start_y; cin = start_c; din = start_d;
                end else cnt_pend++;
            end else if (mst[s] == 1) begin
                if (res_inf) begin
                    why = "R6"; cnt_inf++;
                end else if (res_x[XW-1 -: 3] == 3'b101) begin
                    why = "R5";
                    if (free) rep = 1'b1;
                    else begin
                        cnt_hold++; why = "R10";
                    end
                end else if (mlen[s] + 1 > MAX_LEN) begin
                    why = "R7"; cnt_len++;
                end else begin
                    e_iv = 1'b1;
                end
            end else begin
                why = "R10";
                if (free) begin
                    rep = 1'b1; rx = mx[s]; ry = my[s];
                end
            end

            chk("R1 iss_slot rotation", 32'(iss_slot), 32'(s));
            chk({why, "/R9 start_ready"}, 32'(start_ready), 32'(e_sr));
            chk({why, "/R9 iss_valid"}, 32'(iss_valid), 32'(e_iv));
            if (e_iv) begin
                chk({why, " iss_x"}, 32'(iss_x), 32'(ix));
                chk({why, " iss_y"}, 32'(iss_y), 32'(iy));
                chk("R2 iss_part", 32'(iss_part), 32'(ix[4:0]));
            end
            chk("R5/R10 dp_valid", 32'(dp_valid), 32'(mdv));
            if (mdv) begin
                chk("R5/R10 dp_slot", 32'(dp_slot), 32'(mdslot));
                chk("R5/R10 dp_x", 32'(dp_x), 32'(mdx));
                chk("R5/R10 dp_y", 32'(dp_y), 32'(mdy));
                chk("R3/R4 dp_c", 32'(dp_c), 32'(mdc));
                chk("R3/R4 dp_d", 32'(dp_d), 32'(mdd));
            end

            // advance the model across the coming edge
            if (mdv && dpr) mdv = 1'b0;
            if (rep) begin
                mdv = 1'b1; mdslot = SW'(s); mdx = rx; mdy = ry; mdc = mc[s]; mdd = md[s];
                cnt_dp++;
            end
            if (mst[s] == 0) begin
                if (sv) begin
                    mst[s] = 1; mlen[s] = 0;
                    tix = (tix + 1) % NSTART;
                end
            end else if (mst[s] == 1) begin
                if (res_inf) mst[s] = 0;
                else if (res_x[XW-1 -: 3] == 3'b101) begin
                    if (rep) mst[s] = 0;
                    else begin
                        mst[s] = 2; mx[s] = res_x; my[s] = res_y;
                    end
                end else if (mlen[s] + 1 > MAX_LEN) mst[s] = 0;
                else mlen[s] = mlen[s] + 1;
            end else if (rep) mst[s] = 0;
            if (e_iv) begin
                mc[s] = CW'((int'(cin) + int'(e_of(int'(ix[4:0])))) % ORDER);
                md[s] = CW'((int'(din) + int'(f_of(int'(ix[4:0])))) % ORDER);
            end
            mptr = (mptr + 1) % NCH;

            // pipeline stub: result returns NCH cycles after the issue
            qv   = e_iv;
            qx   = stub_x(ix, iy, ix[4:0]);
            qy   = stub_y(ix, iy, ix[4:0]);
            qinf = force_inf && (s == 2);
            for (int i = NCH - 1; i > 0; i--) begin
                pv[i] = pv[i-1]; px[i] = px[i-1]; py[i] = py[i-1]; pinf[i] = pinf[i-1];
            end
            pv[0] = qv; px[0] = qx; py[0] = qy; pinf[0] = qinf;

            @(negedge clk);
        end

        // every corner the requirements name was reached
        chk("R5 distinguished reports seen", 32'(cnt_dp > 0), 32'd1);
        chk("R6 infinity retirements seen", 32'(cnt_inf > 0), 32'd1);
        chk("R7 length retirements seen", 32'(cnt_len > 0), 32'd1);
        chk("R10 held reports seen", 32'(cnt_hold > 0), 32'd1);
        chk("R8 pending idle slots seen", 32'(cnt_pend > 0), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule